// File: doc/BRIEF.md
# Cache Allocation Stall Controller

This block sits beside the two allocation queues of a non-blocking cache. One queue tracks outstanding misses. The other holds writes and writebacks. Each queue is modelled only by its occupancy count. The block accepts allocation requests and mark-in-service events, and it keeps a three-bit mask of independent stall causes. From that mask it drives one upstream stall line.

When a stall episode begins, the block counts the episode against the cause that started it. When the episode ends, it adds the episode's length in cycles to the cause whose removal ended it. Every accepted allocation produces a formatted entry descriptor with an increasing order number. If asked, an accepted allocation also raises a downstream bus request tagged with the queue that caused it. A prefetch source can raise a request in any cycle that no allocation claims.

The cache pipeline uses the stall line to hold off new requests. The counters are read by performance logic elsewhere in the chip.

Top module: `alloc_stall_ctrl`

## Requirements
- R1: After reset the mask is 0, the stall is low, every event counter and cycle total is 0, the error flag is low, and neither an entry nor a bus request is presented.
- R2: Mask bit 0 means the miss queue is full, bit 1 means the write buffer is full, and bit 2 means no targets are free. The stall output is high exactly when the mask is nonzero. Both follow their cause one clock later.
- R3: An accepted allocation that brings its queue to its depth sets that queue's mask bit. Allocation kind 00 (cacheable miss) and 01 (uncached read) go to the miss queue. Kinds with bit 1 set (write) go to the write buffer.
- R4: A service event on a full queue lowers its occupancy and clears its mask bit. A service event on a queue that is not full leaves the mask alone. A service event on an empty queue has no effect.
- R5: The targets cause is set by tgt_set and cleared by tgt_clr. When both are high in the same cycle, set wins.
- R6: When the mask goes from zero to nonzero, the event counter of the lowest-indexed newly set cause increments. No counter moves while the mask was already nonzero.
- R7: When the mask goes from nonzero to zero, the cycle total of the lowest-indexed cause cleared in that cycle grows by the number of cycles the stall was high.
- R8: A kind 00 entry carries the address rounded down to BLK_BYTES and a size of BLK_BYTES. Every other kind carries the request's own address and size.
- R9: Accepted allocations receive order numbers 0, 1, 2, … in acceptance order. Each is presented on ent_order with ent_valid high for one cycle.
- R10: bus_req_cause is 0 for the miss queue, 1 for the write buffer and 2 for a prefetch. An accepted allocation with alloc_bus_req takes priority over pf_req. Nothing is issued while retry_pending is high.
- R11: An allocation into a full queue is dropped. It produces no entry, no order number, no occupancy change and no bus request, and it sets alloc_err, which stays high until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_valid | input | 1 | Allocation request |
| alloc_kind | input | 2 | 00 cacheable miss, 01 uncached read, 1x write |
| alloc_addr | input | AW | Request address |
| alloc_size | input | SW | Request size in bytes |
| alloc_bus_req | input | 1 | Raise a bus request if accepted |
| svc_valid | input | 1 | Mark-in-service event |
| svc_queue | input | 1 | 0 miss queue, 1 write buffer |
| tgt_set | input | 1 | Raise the no-targets cause |
| tgt_clr | input | 1 | Drop the no-targets cause |
| pf_req | input | 1 | Prefetch bus request |
| retry_pending | input | 1 | Downstream retry outstanding |
| stall | output | 1 | Upstream stall |
| block_mask | output | 3 | Per-cause stall mask |
| alloc_err | output | 1 | Sticky full-queue allocation error |
| ent_valid | output | 1 | Entry descriptor valid |
| ent_kind | output | 2 | Entry kind |
| ent_addr | output | AW | Entry address |
| ent_size | output | SW | Entry size |
| ent_order | output | OW | Entry order number |
| bus_req_valid | output | 1 | Bus request pulse |
| bus_req_cause | output | 2 | Bus request cause |
| evt_cnt | output | 3*CW | Per-cause stall episode counts, cause i at bits i*CW |
| cyc_tot | output | 3*TW | Per-cause stalled-cycle totals, cause i at bits i*TW |

## Verification
Every result of this block appears one clock after the inputs that cause it are sampled. This covers the mask, the stall, the entry descriptor, the bus request, the error flag and both sets of counters. The bench drives each cycle's inputs at the falling edge and advances its reference model by the same step. It compares all outputs at the next falling edge, so each check lands exactly on the cycle that follows the rising edge. Directed sequences stall on one cause at a time and on overlapping causes. Seeded random traffic then alternates between fill-heavy and drain-heavy phases.

// File: rtl/asc_pkg.sv
package asc_pkg;
   localparam int NCAUSE    = 3;
   localparam int CAUSE_MQ  = 0;
   localparam int CAUSE_WB  = 1;
   localparam int CAUSE_TGT = 2;

   localparam logic [1:0] KIND_CMISS = 2'b00;
   localparam logic [1:0] KIND_UREAD = 2'b01;

   localparam logic [1:0] BUS_MQ = 2'd0;
   localparam logic [1:0] BUS_WB = 2'd1;
   localparam logic [1:0] BUS_PF = 2'd2;
endpackage

// File: rtl/asc_queue_occ.sv
module asc_queue_occ #(
   parameter int DEPTH = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic alloc,
   input  logic svc,
   output logic full,
   output logic accept,
   output logic set_cause,
   output logic clr_cause
);
   localparam int CW = $clog2(DEPTH + 1);

   logic [CW-1:0] occ, occ_next;
   logic          svc_ok;

   always_comb begin
      full      = (occ == CW'(DEPTH));
      accept    = alloc && !full;
      svc_ok    = svc && (occ != '0);
      occ_next  = occ + CW'(accept) - CW'(svc_ok);
      set_cause = accept && (occ_next == CW'(DEPTH));
      clr_cause = svc_ok && full;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) occ <= '0;
      else        occ <= occ_next;
   end
endmodule

// File: rtl/asc_block_acct.sv
module asc_block_acct #(
   parameter int NC = 3,
   parameter int CW = 16,
   parameter int TW = 24
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic [NC-1:0]  set_bits,
   input  logic [NC-1:0]  clr_bits,
   output logic [NC-1:0]  mask,
   output logic           stall,
   output logic [NC*CW-1:0] evt_cnt,
   output logic [NC*TW-1:0] cyc_tot
);
   localparam int IW = $clog2(NC);

   logic [NC-1:0] mask_next, clr_live;
   logic          start, stop;
   logic [IW-1:0] start_idx, stop_idx;
   logic [TW-1:0] run;

   always_comb begin
      mask_next = (mask & ~clr_bits) | set_bits;
      clr_live  = clr_bits & mask & ~set_bits;
      start     = (mask == '0) && (mask_next != '0);
      stop      = (mask != '0) && (mask_next == '0);
      start_idx = '0;
      stop_idx  = '0;
      for (int i = NC - 1; i >= 0; i--) begin
         if (mask_next[i]) start_idx = IW'(i);
         if (clr_live[i])  stop_idx  = IW'(i);
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mask  <= '0;
         stall <= 1'b0;
         run   <= '0;
      end else begin
         mask <= mask_next;
         if (start)      begin stall <= 1'b1; run <= TW'(1); end
         else if (stop)  begin stall <= 1'b0; run <= '0;     end
         else if (stall) run <= run + 1'b1;
      end
   end

   for (genvar g = 0; g < NC; g++) begin : g_cause
      logic [CW-1:0] evt;
      logic [TW-1:0] tot;
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            evt <= '0;
            tot <= '0;
         end else begin
            if (start && start_idx == IW'(g)) evt <= evt + 1'b1;
            if (stop && stop_idx == IW'(g))   tot <= tot + run;
         end
      end
      assign evt_cnt[g*CW +: CW] = evt;
      assign cyc_tot[g*TW +: TW] = tot;
   end
endmodule

// File: rtl/asc_entry_gen.sv
module asc_entry_gen
   import asc_pkg::*;
#(
   parameter int AW        = 32,
   parameter int SW        = 8,
   parameter int OW        = 16,
   parameter int BLK_BYTES = 64
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          accept,
   input  logic [1:0]    kind,
   input  logic [AW-1:0] addr,
   input  logic [SW-1:0] size,
   input  logic          bus_en,
   input  logic          pf_req,
   input  logic          retry_pending,
   output logic          ent_valid,
   output logic [1:0]    ent_kind,
   output logic [AW-1:0] ent_addr,
   output logic [SW-1:0] ent_size,
   output logic [OW-1:0] ent_order,
   output logic          bus_req_valid,
   output logic [1:0]    bus_req_cause
);
   localparam int OFFW = $clog2(BLK_BYTES);

   logic [AW-1:0] aligned;
   logic [OW-1:0] ord_cnt;

   if (OFFW == 0) begin : g_noalign
      assign aligned = addr;
   end else begin : g_align
      assign aligned = {addr[AW-1:OFFW], {OFFW{1'b0}}};
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ent_valid     <= 1'b0;
         ent_kind      <= '0;
         ent_addr      <= '0;
         ent_size      <= '0;
         ent_order     <= '0;
         ord_cnt       <= '0;
         bus_req_valid <= 1'b0;
         bus_req_cause <= '0;
      end else begin
         ent_valid <= accept;
         if (accept) begin
            ent_kind  <= kind;
            ent_addr  <= (kind == KIND_CMISS) ? aligned : addr;
            ent_size  <= (kind == KIND_CMISS) ? SW'(BLK_BYTES) : size;
            ent_order <= ord_cnt;
            ord_cnt   <= ord_cnt + 1'b1;
         end
         if (retry_pending) begin
            bus_req_valid <= 1'b0;
         end else if (accept && bus_en) begin
            bus_req_valid <= 1'b1;
            bus_req_cause <= kind[1] ? BUS_WB : BUS_MQ;
         end else if (pf_req) begin
            bus_req_valid <= 1'b1;
            bus_req_cause <= BUS_PF;
         end else begin
            bus_req_valid <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/alloc_stall_ctrl.sv
module alloc_stall_ctrl
   import asc_pkg::*;
#(
   parameter int AW        = 32,
   parameter int SW        = 8,
   parameter int OW        = 16,
   parameter int BLK_BYTES = 64,
   parameter int MQ_DEPTH  = 4,
   parameter int WB_DEPTH  = 4,
   parameter int CW        = 16,
   parameter int TW        = 24
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  alloc_valid,
   input  logic [1:0]            alloc_kind,
   input  logic [AW-1:0]         alloc_addr,
   input  logic [SW-1:0]         alloc_size,
   input  logic                  alloc_bus_req,
   input  logic                  svc_valid,
   input  logic                  svc_queue,
   input  logic                  tgt_set,
   input  logic                  tgt_clr,
   input  logic                  pf_req,
   input  logic                  retry_pending,
   output logic                  stall,
   output logic [2:0]            block_mask,
   output logic                  alloc_err,
   output logic                  ent_valid,
   output logic [1:0]            ent_kind,
   output logic [AW-1:0]         ent_addr,
   output logic [SW-1:0]         ent_size,
   output logic [OW-1:0]         ent_order,
   output logic                  bus_req_valid,
   output logic [1:0]            bus_req_cause,
   output logic [3*CW-1:0]       evt_cnt,
   output logic [3*TW-1:0]       cyc_tot
);
   localparam int NQ = 2;

   if ((BLK_BYTES & (BLK_BYTES - 1)) != 0 || BLK_BYTES < 1) begin : g_bad_blk
      $error("BLK_BYTES must be a power of two");
   end
   if (BLK_BYTES >= (1 << SW)) begin : g_bad_sw
      $error("SW too narrow for BLK_BYTES");
   end
   if (MQ_DEPTH < 1 || WB_DEPTH < 1) begin : g_bad_depth
      $error("queue depths must be at least 1");
   end
   if (CW < 1 || TW < 2 || OW < 1) begin : g_bad_cnt
      $error("counter widths too small");
   end

   logic [NQ-1:0]     q_full, q_acc, q_set, q_clr;
   logic [NCAUSE-1:0] set_bits, clr_bits;

   for (genvar g = 0; g < NQ; g++) begin : g_q
      localparam int D = (g == 0) ? MQ_DEPTH : WB_DEPTH;
      asc_queue_occ #(.DEPTH(D)) u_occ (
         .clk       (clk),
         .rst_n     (rst_n),
         .alloc     (alloc_valid && (alloc_kind[1] == 1'(g))),
         .svc       (svc_valid && (svc_queue == 1'(g))),
         .full      (q_full[g]),
         .accept    (q_acc[g]),
         .set_cause (q_set[g]),
         .clr_cause (q_clr[g])
      );
   end

   assign set_bits = {tgt_set, q_set};
   assign clr_bits = {tgt_clr && !tgt_set, q_clr};

   asc_block_acct #(.NC(NCAUSE), .CW(CW), .TW(TW)) u_acct (
      .clk      (clk),
      .rst_n    (rst_n),
      .set_bits (set_bits),
      .clr_bits (clr_bits),
      .mask     (block_mask),
      .stall    (stall),
      .evt_cnt  (evt_cnt),
      .cyc_tot  (cyc_tot)
   );

   asc_entry_gen #(.AW(AW), .SW(SW), .OW(OW), .BLK_BYTES(BLK_BYTES)) u_ent (
      .clk           (clk),
      .rst_n         (rst_n),
      .accept        (|q_acc),
      .kind          (alloc_kind),
      .addr          (alloc_addr),
      .size          (alloc_size),
      .bus_en        (alloc_bus_req),
      .pf_req        (pf_req),
      .retry_pending (retry_pending),
      .ent_valid     (ent_valid),
      .ent_kind      (ent_kind),
      .ent_addr      (ent_addr),
      .ent_size      (ent_size),
      .ent_order     (ent_order),
      .bus_req_valid (bus_req_valid),
      .bus_req_cause (bus_req_cause)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) alloc_err <= 1'b0;
      else if (alloc_valid && q_full[alloc_kind[1]]) alloc_err <= 1'b1;
   end
endmodule

// File: rtl/asc_checker.sv
module asc_checker #(
   parameter int AW        = 32,
   parameter int SW        = 8,
   parameter int OW        = 16,
   parameter int BLK_BYTES = 64
) (
   input logic          clk,
   input logic          rst_n,
   input logic          retry_pending,
   input logic          stall,
   input logic [2:0]    block_mask,
   input logic          alloc_err,
   input logic          ent_valid,
   input logic [1:0]    ent_kind,
   input logic [AW-1:0] ent_addr,
   input logic [SW-1:0] ent_size,
   input logic [OW-1:0] ent_order,
   input logic          bus_req_valid
);
   // R2
   stall_tracks_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
      stall == (block_mask != 3'b000));

   // R3
   mq_full_from_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(block_mask[0]) |-> (ent_valid && !ent_kind[1]));

   // R3
   wb_full_from_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(block_mask[1]) |-> (ent_valid && ent_kind[1]));

   // R8
   block_aligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ent_valid && ent_kind == 2'b00) |->
         ((ent_addr & AW'(BLK_BYTES - 1)) == '0 && ent_size == SW'(BLK_BYTES)));

   // R9
   order_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ent_valid && $past(ent_valid)) |-> ent_order == OW'($past(ent_order) + 1'b1));

   // R10
   no_issue_in_retry_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bus_req_valid |-> !$past(retry_pending));

   // R11
   err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      alloc_err |=> alloc_err);
endmodule

bind alloc_stall_ctrl asc_checker #(
   .AW(AW), .SW(SW), .OW(OW), .BLK_BYTES(BLK_BYTES)
) u_asc_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .retry_pending (retry_pending),
   .stall         (stall),
   .block_mask    (block_mask),
   .alloc_err     (alloc_err),
   .ent_valid     (ent_valid),
   .ent_kind      (ent_kind),
   .ent_addr      (ent_addr),
   .ent_size      (ent_size),
   .ent_order     (ent_order),
   .bus_req_valid (bus_req_valid)
);

// File: tb/alloc_stall_ctrl_tb_top.sv
module alloc_stall_ctrl_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int AW = 32, SW = 8, OW = 12, BLK = 64;
   localparam int MQD = 4, WBD = 3, CW = 16, TW = 24;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic          alloc_valid = 0, alloc_bus_req = 0, svc_valid = 0, svc_queue = 0;
   logic [1:0]    alloc_kind = 0;
   logic [AW-1:0] alloc_addr = 0;
   logic [SW-1:0] alloc_size = 0;
   logic          tgt_set = 0, tgt_clr = 0, pf_req = 0, retry_pending = 0;
   logic          stall, alloc_err, ent_valid, bus_req_valid;
   logic [2:0]    block_mask;
   logic [1:0]    ent_kind, bus_req_cause;
   logic [AW-1:0] ent_addr;
   logic [SW-1:0] ent_size;
   logic [OW-1:0] ent_order;
   logic [3*CW-1:0] evt_cnt;
   logic [3*TW-1:0] cyc_tot;

   always #(CLK_PERIOD / 2) clk = ~clk;

   alloc_stall_ctrl #(.AW(AW), .SW(SW), .OW(OW), .BLK_BYTES(BLK), .MQ_DEPTH(MQD),
                      .WB_DEPTH(WBD), .CW(CW), .TW(TW)) dut_i (.*);

   int n_chk = 0, n_err = 0;
   bit done = 0;

   // reference model state
   int m_occ[2];
   logic [2:0] m_mask;
   int m_evt[3], m_tot[3], m_run, m_ord;
   bit m_err;
   bit e_valid, e_bus;
   logic [1:0] e_kind, e_cause;
   logic [AW-1:0] e_addr;
   logic [SW-1:0] e_size;

   function automatic int depth_of(int q);
      return (q == 0) ? MQD : WBD;
   endfunction

   function automatic int lowest(logic [2:0] v);
      for (int i = 0; i < 3; i++) if (v[i]) return i;
      return 0;
   endfunction

   task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic model_reset();
      m_occ[0] = 0; m_occ[1] = 0; m_mask = 0; m_run = 0; m_ord = 0; m_err = 0;
      for (int i = 0; i < 3; i++) begin m_evt[i] = 0; m_tot[i] = 0; end
      e_valid = 0; e_bus = 0;
   endtask

   task automatic check_all(string mtag, bit was_rej);
      chk("R2", "stall", 64'(stall), 64'(m_mask != 0));
      chk(mtag, "mask", 64'(block_mask), 64'(m_mask));
      chk("R11", "alloc_err", 64'(alloc_err), 64'(m_err));
      chk(was_rej ? "R11" : "R9", "ent_valid", 64'(ent_valid), 64'(e_valid));
      if (e_valid) begin
         chk("R8", "ent_addr", 64'(ent_addr), 64'(e_addr));
         chk("R8", "ent_size", 64'(ent_size), 64'(e_size));
         chk("R9", "ent_order", 64'(ent_order), 64'(OW'(m_ord - 1)));
         chk("R3", "ent_kind", 64'(ent_kind), 64'(e_kind));
      end
      chk("R10", "bus_req_valid", 64'(bus_req_valid), 64'(e_bus));
      if (e_bus) chk("R10", "bus_req_cause", 64'(bus_req_cause), 64'(e_cause));
      for (int i = 0; i < 3; i++) begin
         chk("R6", "evt_cnt", 64'(evt_cnt[i*CW +: CW]), 64'(CW'(m_evt[i])));
         chk("R7", "cyc_tot", 64'(cyc_tot[i*TW +: TW]), 64'(TW'(m_tot[i])));
      end
   endtask

   task automatic cyc(bit av, logic [1:0] k, logic [AW-1:0] a, logic [SW-1:0] sz, bit br,
                      bit sv, bit sq, bit ts, bit tc, bit pf, bit rt);
      int q;
      bit full, acc, sok, sfull, rej;
      logic [2:0] setb, clrb, nm;
      string mtag;
      alloc_valid = av; alloc_kind = k; alloc_addr = a; alloc_size = sz;
      alloc_bus_req = br; svc_valid = sv; svc_queue = sq; tgt_set = ts;
      tgt_clr = tc; pf_req = pf; retry_pending = rt;
      q = int'(k[1]);
      full = (m_occ[q] == depth_of(q));
      acc = av && !full;
      rej = av && full;
      if (rej) m_err = 1;
      sok = sv && m_occ[sq] > 0;
      sfull = (m_occ[sq] == depth_of(int'(sq)));
      setb = 0; clrb = 0;
      if (acc) m_occ[q]++;
      if (sok) m_occ[sq]--;
      if (acc && m_occ[q] == depth_of(q)) setb[q] = 1;
      if (sok && sfull) clrb[sq] = 1;
      if (ts) setb[2] = 1; else if (tc) clrb[2] = 1;
      nm = (m_mask & ~clrb) | setb;
      if (m_mask == 0 && nm != 0) begin m_evt[lowest(nm)]++; m_run = 1; end
      else if (m_mask != 0 && nm == 0) begin m_tot[lowest(clrb & m_mask)] += m_run; m_run = 0; end
      else if (m_mask != 0) m_run++;
      m_mask = nm;
      mtag = (ts || tc) ? "R5" : (setb != 0) ? "R3" : (sv ? "R4" : "R2");
      e_valid = acc;
      if (acc) begin
         e_kind = k;
         e_addr = (k == 2'b00) ? (a & ~AW'(BLK - 1)) : a;
         e_size = (k == 2'b00) ? SW'(BLK) : sz;
         m_ord++;
      end
      if (!rt && acc && br) begin e_bus = 1; e_cause = k[1] ? 2'd1 : 2'd0; end
      else if (!rt && pf) begin e_bus = 1; e_cause = 2'd2; end
      else e_bus = 0;
      @(negedge clk);
      check_all(mtag, rej);
   endtask

   task automatic idle();
      cyc(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
   endtask

   initial begin
      model_reset();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check_all("R1", 0); // R1 reset state
      // R4: service on empty queue is ignored
      cyc(0, 0, 0, 0, 0, 1, 0, 0, 0, 0, 0);
      // R3 R8 R10: fill miss queue with unaligned cacheable misses
      for (int i = 0; i < MQD; i++) cyc(1, 2'b00, 32'h1000_0000 + 32'(i * 70 + 5), 8'd4, 1, 0, 0, 0, 0, 0, 0);
      idle();
      // R11: allocation into full queue, prefetch wins the bus (R10)
      cyc(1, 2'b01, 32'h2000_0013, 8'd2, 1, 0, 0, 0, 0, 1, 0);
      // R5: set and clear together, set wins
      cyc(0, 0, 0, 0, 0, 0, 0, 1, 1, 0, 0);
      // R10: write buffer fill, one under retry
      cyc(1, 2'b10, 32'h3000_0007, 8'd8, 1, 0, 0, 0, 0, 0, 1);
      cyc(1, 2'b11, 32'h3000_0011, 8'd3, 1, 0, 0, 0, 0, 1, 0);
      cyc(1, 2'b10, 32'h3000_0021, 8'd1, 1, 0, 0, 0, 0, 0, 0);
      // R4 R7: drain causes, targets ends the episode
      cyc(0, 0, 0, 0, 0, 1, 0, 0, 0, 0, 0);
      cyc(0, 0, 0, 0, 0, 1, 1, 0, 0, 0, 0);
      cyc(0, 0, 0, 0, 0, 1, 1, 0, 0, 0, 0);
      idle();
      cyc(0, 0, 0, 0, 0, 0, 0, 0, 1, 0, 0);
      // R6 R7: write buffer alone stalls and unstalls
      for (int i = 0; i < WBD; i++) cyc(1, 2'b10, 32'h4000_0000 + 32'(i), 8'd16, 0, 0, 0, 0, 0, 0, 0);
      repeat (5) idle();
      cyc(0, 0, 0, 0, 0, 1, 1, 0, 0, 0, 0);
      // random traffic in alternating fill and drain phases
      void'($urandom(32'd20240611));
      for (int n = 0; n < 4000; n++) begin
         bit fill = ((n / 40) % 2) == 0;
         int pa = fill ? 60 : 15;
         int ps = fill ? 15 : 60;
         cyc(($urandom % 100) < pa, 2'($urandom), $urandom, 8'($urandom), $urandom % 2,
             ($urandom % 100) < ps, $urandom % 2, ($urandom % 100) < 5,
             ($urandom % 100) < 8, ($urandom % 100) < 10, ($urandom % 100) < 20);
      end
      done = 1;
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_err++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
         $finish;
      end
   end
endmodule